// File: doc/BRIEF.md
# Output-Compare Channel with Coherent Byte-Loaded Compare

This block is one channel of a timer peripheral on an 8-bit register bus. A free-running 16-bit count and a timer-clock enable come from outside. Software loads the 16-bit compare value with two byte writes, in either order. Each byte goes into a holding buffer. The active compare register takes the buffer as one word only after both bytes have arrived.

Any write to the channel's control register resets the byte-pairing state. A byte that was written before that write no longer counts toward a pair. When the counter equals the active compare value on a timer-clock enable, the channel sets its flag and applies the selected pin action. It raises an interrupt request when interrupts are enabled.

In output-compare mode with the timer clock running, the buffer moves to the active register on the next timer-clock enable after the second byte. In all other cases it moves on the following bus clock.

Top module: `oc_channel`

## Requirements
- R1: After reset the control register reads 0x00, the compare value reads CMP_INIT (0x0000), and both pin_out and irq are 0.
- R2: Writing one compare byte (address 1 = high byte, address 2 = low byte) leaves the active compare value unchanged. Reads of addresses 1 and 2 return the active value, not the buffer.
- R3: Once both bytes have been written, high then low or low then high, the active compare value becomes the 16-bit word {high, low}.
- R4: In output-compare mode (mode field 01) with tclk_on=1, the transfer does not happen before a tick. It happens on the first tick after the second byte write.
- R5: With tclk_on=0, or with a mode other than 01, the transfer happens on the clock edge that follows the second byte write.
- R6: A write to the control register (address 0) discards any byte already latched. A transfer then needs a fresh high byte and a fresh low byte written after it.
- R7: The flag (control bit 7) is set only on a tick in mode 01 with count equal to the active compare value. A match without a tick, or a tick without a match, does nothing.
- R8: On a match, the action field (control bits 3:2) drives pin_out: 00 leaves it unchanged, 01 toggles it, 10 drives it low, 11 drives it high. Without a match, pin_out holds.
- R9: irq is 1 exactly when the flag is set and the interrupt enable (control bit 6) is 1.
- R10: A control write clears the flag only if a read of the control register took place while the flag was set. A control write with no such read leaves the flag set.
- R11: The control register reads back as {flag, enable, mode[1:0], action[1:0], 2'b00}. Address 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and channel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| count | input | 16 | Free-running timer count |
| tick | input | 1 | Prescaled timer-clock enable |
| tclk_on | input | 1 | Timer clock source selected (1) or stopped (0) |
| pin_out | output | 1 | Channel pin |
| irq | output | 1 | Interrupt request |

## Verification
The compare load is swept over both byte orders, both timer-clock states and several word values. This separates a transfer that waits for a tick from one that happens at once, and a correct high/low split from a swapped one. One sequence inserts a control write between the two bytes, and later repeats the same byte, to show that a stale half is discarded. The match test walks every action code through repeated matches, near-miss counts and untimed matches. This separates toggle from set/clear and a real match from a spurious one. The flag and interrupt sequences compare a control write with a prior read against one without, under both interrupt-enable settings.

// File: rtl/oc_channel.sv
module oc_channel #(
  parameter logic [15:0] CMP_INIT = 16'h0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [1:0]  addr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  input  logic [15:0] count,
  input  logic        tick,
  input  logic        tclk_on,
  output logic        pin_out,
  output logic        irq
);

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_HI   = 2'd1;
  localparam logic [1:0] A_LO   = 2'd2;
  localparam logic [1:0] M_OC   = 2'b01;

  logic        flag, ie, armed;
  logic [1:0]  mode, act;
  logic [15:0] cmp, hold;
  logic        hi_w, lo_w;

  wire ctrl_wr = wr_en && addr == A_CTRL;
  wire hi_wr   = wr_en && addr == A_HI;
  wire lo_wr   = wr_en && addr == A_LO;
  wire oc      = mode == M_OC;
  wire both    = hi_w & lo_w;
  wire xfer    = both && !ctrl_wr && (!(oc && tclk_on) || tick);
  wire hit     = oc && tick && count == cmp;

  logic unused_bits;
  assign unused_bits = &{1'b0, wdata[7], wdata[1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp  <= CMP_INIT;
      hold <= CMP_INIT;
      hi_w <= 1'b0;
      lo_w <= 1'b0;
    end else if (ctrl_wr) begin
      hi_w <= 1'b0;
      lo_w <= 1'b0;
    end else begin
      if (xfer) begin
        cmp  <= hold;
        hi_w <= 1'b0;
        lo_w <= 1'b0;
      end
      if (hi_wr) begin
        hold[15:8] <= wdata;
        hi_w       <= 1'b1;
      end
      if (lo_wr) begin
        hold[7:0] <= wdata;
        lo_w      <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie   <= 1'b0;
      mode <= 2'b00;
      act  <= 2'b00;
    end else if (ctrl_wr) begin
      ie   <= wdata[6];
      mode <= wdata[5:4];
      act  <= wdata[3:2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else begin
      if (hit)                   flag <= 1'b1;
      else if (ctrl_wr && armed) flag <= 1'b0;
      if (ctrl_wr)                                armed <= 1'b0;
      else if (rd_en && addr == A_CTRL && flag)   armed <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_out <= 1'b0;
    else if (hit) begin
      case (act)
        2'b01:   pin_out <= ~pin_out;
        2'b10:   pin_out <= 1'b0;
        2'b11:   pin_out <= 1'b1;
        default: pin_out <= pin_out;
      endcase
    end
  end

  assign irq = flag & ie;

  always_comb begin
    case (addr)
      A_CTRL:  rdata = {flag, ie, mode, act, 2'b00};
      A_HI:    rdata = cmp[15:8];
      A_LO:    rdata = cmp[7:0];
      default: rdata = 8'h00;
    endcase
  end

endmodule

// File: rtl/oc_channel_chk.sv
module oc_channel_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ctrl_wr,
  input logic        hi_w,
  input logic        lo_w,
  input logic [15:0] cmp,
  input logic        hit,
  input logic        flag,
  input logic        ie,
  input logic [1:0]  act,
  input logic        pin_out,
  input logic        irq
);

  // R6
  latch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (!hi_w && !lo_w));

  // R2
  cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_w && lo_w) |=> $stable(cmp));

  // R7
  match_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag);

  // R8
  pin_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && act == 2'b10) |=> !pin_out);

  // R8
  pin_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && act == 2'b11) |=> pin_out);

  // R8
  pin_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && act == 2'b01) |=> pin_out != $past(pin_out));

  // R8
  pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(pin_out));

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ie && flag));

endmodule

bind oc_channel oc_channel_chk chk (
  .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .hi_w(hi_w), .lo_w(lo_w),
  .cmp(cmp), .hit(hit), .flag(flag), .ie(ie), .act(act),
  .pin_out(pin_out), .irq(irq)
);

// File: tb/oc_channel_test.sv
module oc_channel_test;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, tick = 0, tclk_on = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic [15:0] count = 0;
  logic pin_out, irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  oc_channel uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .count(count), .tick(tick),
    .tclk_on(tclk_on), .pin_out(pin_out), .irq(irq));

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1; addr = a; wdata = d; step(); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_en = 1; addr = a; #1 d = rdata; step(); rd_en = 0;
  endtask

  task automatic rd_cmp(output logic [15:0] v);
    logic [7:0] h, l;
    rd(2'd1, h); rd(2'd2, l); v = {h, l};
  endtask

  task automatic match();
    count = 16'h0040; tick = 1; step(); tick = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [15:0] v, prev, nv;
    logic p;
    repeat (3) step();
    rst_n = 1; step();

    rd(2'd0, d); chk("R1 ctrl", d, 8'h00);
    rd_cmp(v);   chk("R1 cmp", v, 16'h0000);
    chk("R1 pin", pin_out, 0);
    chk("R1 irq", irq, 0);

    for (int on = 0; on < 2; on++)
      for (int ord = 0; ord < 2; ord++)
        for (int k = 0; k < 4; k++) begin
          tclk_on = on[0];
          wr(2'd0, 8'h10);
          rd_cmp(prev);
          nv = 16'h1357 * (k + 1) + 16'h0101 * ord + 16'h2000 * on;
          if (ord == 0) wr(2'd1, nv[15:8]); else wr(2'd2, nv[7:0]);
          rd_cmp(v); chk("R2 single byte", v, prev);
          if (ord == 0) wr(2'd2, nv[7:0]); else wr(2'd1, nv[15:8]);
          if (on) begin
            step(); step();
            rd_cmp(v); chk("R4 no tick yet", v, prev);
            tick = 1; step(); tick = 0;
            rd_cmp(v); chk("R4 R3 after tick", v, nv);
          end else begin
            step();
            rd_cmp(v); chk("R5 R3 immediate", v, nv);
          end
        end

    tclk_on = 1; wr(2'd0, 8'h00);
    wr(2'd2, 8'h3C); wr(2'd1, 8'hA5); step();
    rd_cmp(v); chk("R5 non-OC mode", v, 16'hA53C);

    tclk_on = 0; wr(2'd0, 8'h10);
    wr(2'd1, 8'hAA); wr(2'd0, 8'h10); wr(2'd2, 8'h55); step();
    rd_cmp(v); chk("R6 stale half dropped", v, 16'hA53C);
    wr(2'd2, 8'h66); step();
    rd_cmp(v); chk("R6 low alone", v, 16'hA53C);
    wr(2'd1, 8'h77); step();
    rd_cmp(v); chk("R6 fresh pair", v, 16'h7766);

    wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd2, 8'h40); step();
    p = 0;
    for (int a = 3; a >= 0; a--)
      for (int t = 0; t < 2; t++) begin
        wr(2'd0, 8'h10 | (a[1:0] << 2));
        count = 16'h0040; tick = 0; step();
        rd(2'd0, d); chk("R7 no tick", {d[7], pin_out}, {1'b0, p});
        count = 16'h0041; tick = 1; step(); tick = 0;
        rd(2'd0, d); chk("R7 mismatch", {d[7], pin_out}, {1'b0, p});
        match();
        case (a)
          1: p = !p;
          2: p = 0;
          3: p = 1;
          default: p = p;
        endcase
        chk("R8 pin action", pin_out, p);
        rd(2'd0, d); chk("R7 flag set", d[7], 1);
      end

    wr(2'd0, 8'h5F); rd(2'd0, d); chk("R11 readback", d, 8'h5C);
    rd(2'd3, d); chk("R11 addr3", d, 8'h00);

    wr(2'd0, 8'h58); match();
    chk("R9 irq on", irq, 1);
    chk("R8 pulse end", pin_out, 0);
    wr(2'd0, 8'h58);
    rd(2'd0, d); chk("R10 no read no clear", d[7], 1);
    wr(2'd0, 8'h58);
    rd(2'd0, d); chk("R10 cleared", d[7], 0);
    chk("R9 irq off", irq, 0);
    wr(2'd0, 8'h18); match();
    rd(2'd0, d); chk("R9 flag w/o enable", d[7], 1);
    chk("R9 irq masked", irq, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule